// File: doc/BRIEF.md
# Bus Window Address Capture

This block sits on an 8-bit microprocessor bus and decides, cycle by cycle, whether the processor is addressing a small memory window that the chip emulates. It waits for an active-low qualifying strobe, which combines the valid-memory-address signal with an external partial decode. It then samples two upper address bits. Both bits must be zero for the cycle to be claimed. The strobe must also still be active at that moment. Otherwise the cycle is dropped and the block goes back to waiting.

A claimed cycle has its 11-bit offset read in two phases over one shared group of eight input pins. The block drives an external multiplexer select for this. With the select high, the three middle address bits appear on the low pins. With the select low, the eight lowest address bits appear. Each phase allows a settling time, counted in system clocks, before it samples. The offset is placed under a 21-bit base value. The 32-bit result goes to a downstream data-phase engine over a valid/ready handshake. After the engine accepts the address, the block pulses a start strobe to it. It then refuses to look at the bus again until the engine returns a done pulse.

All bus-side inputs pass through a two-stage synchroniser before any decision uses them.

Top module: `addr_window_capture`

## Requirements
- R1: After reset, and again once a cycle has finished with the strobe inactive, `muxSel`, `addrValid` and `dataStart` are all 0.
- R2: While `qualN` is high, the block never raises `muxSel` or `addrValid`, whatever the values on `hiBits` and `muxPins`.
- R3: A cycle is claimed only when `hiBits` is 2'b00 at the sampling point, which is `QUAL_DLY` clocks after the synchronised strobe is seen low. For any non-zero `hiBits` the block returns to idle without raising `muxSel` or `addrValid`.
- R4: If the synchronised strobe has returned high by that same sampling point, the cycle is abandoned with no `muxSel` pulse and no `addrValid`.
- R5: In a claimed cycle, `muxSel` goes high for `MUX_DLY` clocks. At the end of that window, `muxPins[2:0]` gives address bits 10:8. `muxPins[7:3]` has no effect during this phase.
- R6: After the high phase, `muxSel` returns low for `MUX_DLY` clocks. At the end of that window, `muxPins[7:0]` gives address bits 7:0. `addrOut` = {`baseAddr`[20:0], bits 10:8, bits 7:0}.
- R7: `dataStart` is high for exactly the one clock that follows the clock edge where `addrValid` and `addrReady` are both high. `addrValid` is low in that clock.
- R8: While `addrValid` is high and `addrReady` is low, `addrValid` stays high and `addrOut` does not change.
- R9: Between `dataStart` and the next `dataDone` pulse, the block stays inactive even while `qualN` is held low: `muxSel`, `addrValid` and `dataStart` remain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseAddr | input | 21 | Fixed upper part of the output address, set at configuration time |
| qualN | input | 1 | Active-low combined valid-address and decode strobe from the bus |
| hiBits | input | 2 | The two upper address bits compared against the window |
| muxPins | input | 8 | Shared address pins behind the external multiplexer |
| muxSel | output | 1 | Select for the external multiplexer: 1 = middle bits, 0 = low byte |
| addrOut | output | 32 | Captured full address |
| addrValid | output | 1 | `addrOut` holds a captured address |
| addrReady | input | 1 | Data-phase engine accepts `addrOut` |
| dataStart | output | 1 | One-clock start pulse to the data-phase engine |
| dataDone | input | 1 | One-clock pulse from the data-phase engine when its phase ends |

## Verification
The assertions assume that `baseAddr` does not change while a cycle is in flight. They also assume that `dataDone` arrives only after `dataStart`, and that the strobe goes high again before that done pulse. The bench holds the base constant across each cycle and changes it only between cycles. It raises the strobe before it pulses done. Its bus model drives `muxPins` from the current `muxSel`, which mimics an external multiplexer whose settling time is shorter than `MUX_DLY` minus the synchroniser latency. Random junk goes on the pins that should be ignored.

// File: rtl/awc_pkg.sv
package awc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QWAIT,
    ST_MID,
    ST_LOW,
    ST_ISSUE,
    ST_START,
    ST_HOLD
  } awcState_t;

  typedef struct packed {
    logic clearAcc;
    logic shiftMid;
    logic shiftLow;
  } dpStrobe_t;

endpackage

// File: rtl/awc_sync.sv
module awc_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[g] <= RST_VAL;
          else       pipe[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[g] <= RST_VAL;
          else       pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/awc_ctrl.sv
module awc_ctrl
  import awc_pkg::*;
#(
  parameter int QUAL_DLY = 4,
  parameter int MUX_DLY  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      qualS,
  input  logic      hiZero,
  input  logic      addrReady,
  input  logic      dataDone,
  output dpStrobe_t strb,
  output logic      muxSel,
  output logic      addrValid,
  output logic      dataStart
);

  localparam int MAX_DLY = (QUAL_DLY > MUX_DLY) ? QUAL_DLY : MUX_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] QUAL_LOAD = CNT_W'(QUAL_DLY - 1);
  localparam logic [CNT_W-1:0] MUX_LOAD  = CNT_W'(MUX_DLY - 1);

  awcState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             selNext;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = cntZero ? cnt : cnt - 1'b1;
    selNext   = muxSel;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        strb.clearAcc = 1'b1;
        selNext       = 1'b0;
        if (!qualS) begin
          stateNext = ST_QWAIT;
          cntNext   = QUAL_LOAD;
        end
      end
      ST_QWAIT: begin
        if (cntZero) begin
          if (!hiZero || qualS) begin
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_MID;
            selNext   = 1'b1;
            cntNext   = MUX_LOAD;
          end
        end
      end
      ST_MID: begin
        if (cntZero) begin
          strb.shiftMid = 1'b1;
          stateNext     = ST_LOW;
          selNext       = 1'b0;
          cntNext       = MUX_LOAD;
        end
      end
      ST_LOW: begin
        if (cntZero) begin
          strb.shiftLow = 1'b1;
          stateNext     = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (addrReady) stateNext = ST_START;
      end
      ST_START: begin
        stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (dataDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      muxSel <= 1'b0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      muxSel <= selNext;
    end
  end

  assign addrValid = (state == ST_ISSUE);
  assign dataStart = (state == ST_START);

  // R3: the select only rises after a decision that saw a zero window and a live strobe
  p_sel_after_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muxSel) |-> $past(hiZero && !qualS));

  // R7: start is a single-cycle pulse
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataStart |=> !dataStart);

endmodule

// File: rtl/awc_datapath.sv
module awc_datapath
  import awc_pkg::*;
#(
  parameter int BASE_W = 21,
  parameter int HI_W   = 2,
  parameter int MID_W  = 3,
  parameter int LOW_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strb,
  input  logic [HI_W-1:0]           hiS,
  input  logic [LOW_W-1:0]          pinsS,
  input  logic [BASE_W-1:0]         baseAddr,
  output logic                      hiZero,
  output logic [BASE_W+MID_W+LOW_W-1:0] addrOut
);

  localparam int OFF_W = MID_W + LOW_W;

  logic [OFF_W-1:0]  acc;
  logic [BASE_W-1:0] baseReg;

  assign hiZero = (hiS == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      baseReg <= '0;
    end else begin
      if (strb.clearAcc) begin
        acc <= '0;
      end else if (strb.shiftMid) begin
        acc <= {acc[OFF_W-MID_W-1:0], pinsS[MID_W-1:0]};
      end else if (strb.shiftLow) begin
        acc     <= {acc[OFF_W-LOW_W-1:0], pinsS};
        baseReg <= baseAddr;
      end
    end
  end

  assign addrOut = {baseReg, acc};

endmodule

// File: rtl/addr_window_capture.sv
module addr_window_capture
  import awc_pkg::*;
#(
  parameter int BASE_W      = 21,
  parameter int HI_W        = 2,
  parameter int MID_W       = 3,
  parameter int LOW_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_DLY    = 4,
  parameter int MUX_DLY     = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [BASE_W-1:0]             baseAddr,
  input  logic                          qualN,
  input  logic [HI_W-1:0]               hiBits,
  input  logic [LOW_W-1:0]              muxPins,
  output logic                          muxSel,
  output logic [BASE_W+MID_W+LOW_W-1:0] addrOut,
  output logic                          addrValid,
  input  logic                          addrReady,
  output logic                          dataStart,
  input  logic                          dataDone
);

  localparam int ADDR_W = BASE_W + MID_W + LOW_W;
  localparam int SYNC_W = 1 + HI_W + LOW_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(HI_W + LOW_W){1'b0}}};

  logic [SYNC_W-1:0] busS;
  logic              qualS;
  logic [HI_W-1:0]   hiS;
  logic [LOW_W-1:0]  pinsS;
  logic              hiZero;
  dpStrobe_t         strb;

  awc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({qualN, hiBits, muxPins}),
    .dout (busS)
  );

  assign {qualS, hiS, pinsS} = busS;

  awc_ctrl #(.QUAL_DLY(QUAL_DLY), .MUX_DLY(MUX_DLY)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .qualS     (qualS),
    .hiZero    (hiZero),
    .addrReady (addrReady),
    .dataDone  (dataDone),
    .strb      (strb),
    .muxSel    (muxSel),
    .addrValid (addrValid),
    .dataStart (dataStart)
  );

  awc_datapath #(.BASE_W(BASE_W), .HI_W(HI_W), .MID_W(MID_W), .LOW_W(LOW_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hiS      (hiS),
    .pinsS    (pinsS),
    .baseAddr (baseAddr),
    .hiZero   (hiZero),
    .addrOut  (addrOut)
  );

  // R8: an offered address stays offered and unchanged until taken
  p_hold_until_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> (addrValid && $stable(addrOut)));

  // R7: start follows an accepted handshake
  p_start_after_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataStart |-> $past(addrValid && addrReady));

  // R6: a newly offered address carries the configured base on top
  p_base_on_top_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrValid) |-> (addrOut[ADDR_W-1:ADDR_W-BASE_W] == baseAddr));

  // R2: no select activity begins while the synchronised strobe is inactive in idle
  p_select_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muxSel) |-> !$past(qualS));

endmodule

// File: tb/addr_window_capture_tb.sv
module addr_window_capture_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [20:0] baseAddr = '0;
  logic        qualN = 1'b1;
  logic [1:0]  hiBits = '0;
  logic [7:0]  muxPins;
  logic        muxSel;
  logic [31:0] addrOut;
  logic        addrValid;
  logic        addrReady = 1'b0;
  logic        dataStart;
  logic        dataDone = 1'b0;

  logic [2:0]  midV = '0;
  logic [4:0]  junk = '0;
  logic [7:0]  lowV = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // external multiplexer model
  assign muxPins = muxSel ? {junk, midV} : lowV;

  addr_window_capture u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .baseAddr  (baseAddr),
    .qualN     (qualN),
    .hiBits    (hiBits),
    .muxPins   (muxPins),
    .muxSel    (muxSel),
    .addrOut   (addrOut),
    .addrValid (addrValid),
    .addrReady (addrReady),
    .dataStart (dataStart),
    .dataDone  (dataDone)
  );

  function automatic logic [31:0] expAddr(input logic [20:0] b, input logic [2:0] m,
                                          input logic [7:0] l);
    return {b, m, l};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(!muxSel && !addrValid && !dataStart, req,
          {29'd0, muxSel, addrValid, dataStart}, 32'd0);
  endtask

  task automatic busCycle(input logic [1:0] h, input logic [2:0] m, input logic [7:0] l,
                          input int rdyDly, input int holdLow);
    bit got;
    bit seen;
    bit bad;
    logic [31:0] first;
    @(negedge clk);
    hiBits = h; midV = m; lowV = l; junk = 5'($urandom); qualN = 1'b0;
    if (h != 2'b00) begin
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (muxSel || addrValid) seen = 1'b1;
      end
      check(!seen, "R3 non-zero window claimed", {31'd0, seen}, 32'd0);
      qualN = 1'b1;
      repeat (4) @(negedge clk);
    end else begin
      got = 1'b0;
      for (int i = 0; i < 100 && !got; i++) begin
        @(negedge clk);
        if (addrValid) got = 1'b1;
      end
      check(got, "R3 zero window not claimed", {31'd0, got}, 32'd1);
      check(addrOut[10:8] == m, "R5 middle bits", {29'd0, addrOut[10:8]}, {29'd0, m});
      check(addrOut[7:0] == l, "R6 low byte", {24'd0, addrOut[7:0]}, {24'd0, l});
      check(addrOut == expAddr(baseAddr, m, l), "R6 full address", addrOut,
            expAddr(baseAddr, m, l));
      first = addrOut;
      for (int i = 0; i < rdyDly; i++) begin
        @(negedge clk);
        check(addrValid && addrOut == first, "R8 hold while not ready", addrOut, first);
      end
      addrReady = 1'b1;
      @(negedge clk);
      check(dataStart && !addrValid, "R7 start after accept",
            {30'd0, dataStart, addrValid}, 32'd2);
      addrReady = 1'b0;
      @(negedge clk);
      check(!dataStart, "R7 start one cycle", {31'd0, dataStart}, 32'd0);
      bad = 1'b0;
      for (int i = 0; i < holdLow; i++) begin
        @(negedge clk);
        if (muxSel || addrValid || dataStart) bad = 1'b1;
      end
      check(!bad, "R9 inactive until done", {31'd0, bad}, 32'd0);
      qualN = 1'b1;
      repeat (3) @(negedge clk);
      dataDone = 1'b1;
      @(negedge clk);
      dataDone = 1'b0;
      repeat (2) @(negedge clk);
      checkIdle("R1 idle after cycle");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seen;
    int dummy;
    dummy = $urandom(32'h1f2e3d4c);
    baseAddr = 21'h10_0200;
    repeat (3) @(negedge clk);
    checkIdle("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    // R2: strobe inactive, bus noise
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      hiBits = 2'($urandom); lowV = 8'($urandom); midV = 3'($urandom);
      if (muxSel || addrValid) seen = 1'b1;
    end
    check(!seen, "R2 activity with strobe high", {31'd0, seen}, 32'd0);

    // R4: strobe pulse too short to survive to the sampling point
    hiBits = 2'b00;
    @(negedge clk);
    qualN = 1'b0;
    repeat (2) @(negedge clk);
    qualN = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (muxSel || addrValid) seen = 1'b1;
    end
    check(!seen, "R4 abandoned cycle", {31'd0, seen}, 32'd0);

    // directed corners
    busCycle(2'b00, 3'b111, 8'hFF, 0, 10);
    busCycle(2'b00, 3'b000, 8'h00, 3, 5);
    busCycle(2'b01, 3'b101, 8'h5A, 0, 0);
    busCycle(2'b10, 3'b010, 8'hA5, 0, 0);
    busCycle(2'b11, 3'b001, 8'h01, 0, 0);
    busCycle(2'b00, 3'b100, 8'h80, 1, 2);

    // constrained random
    for (int n = 0; n < 40; n++) begin
      logic [1:0] h;
      if (n % 10 == 0) baseAddr = 21'($urandom);
      h = ($urandom % 4 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
      busCycle(h, 3'($urandom), 8'($urandom), int'($urandom % 6), int'($urandom % 8));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule